// File: doc/BRIEF.md
# Queued SPI Master Serial Engine

This block is a full-duplex, three-wire synchronous serial master built on a UART-style datapath: a transmit holding register feeding a transmit shift register, a receive shift register feeding a receive buffer, a baud divider, and one transfer controller shared by both directions. The serial clock is always generated inside the block and driven out. It supports all four clock polarity and phase combinations, and the bit order can be selected at run time. Frames are eight bits long.

Software-side logic writes bytes through a valid/ready port. A byte is accepted when `tx_valid` and `tx_ready` are both high on a rising clock edge. `tx_ready` is high only when the engine is enabled and the holding register is empty, so a full holding register applies back-pressure. Because the holding register is separate from the shift register, a second byte can be queued while the first is still shifting. The queued byte starts as soon as the first one ends, with no idle serial-clock period between them.

Received bytes appear on `rx_data` with `rx_valid`, and leave the buffer on a cycle where `rx_ready` is high. The serial link itself cannot be stalled. A frame that finishes while the buffer is still unread therefore replaces the old byte, and `rx_valid` stays high.

Top module: `spim_engine`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sck` equals `cpol`. After reset, `dre` is 1, `txc` is 0 and `rx_valid` is 0.
- R2: Every serial clock half-period lasts `baud`+1 system clock cycles, so `baud`=0 gives a serial clock at half the system clock.
- R3: Each frame has exactly 16 `sck` transitions. With `cpha`=0, each data bit is valid before the leading (first) edge of its clock pulse, and the block samples `miso` on that leading edge. With `cpha`=1, each data bit is presented on the leading edge and sampled on the trailing edge.
- R4: With `lsb_first`=1, bit 0 of the byte is transmitted first and the first received bit lands in bit 0. With `lsb_first`=0, bit 7 goes first and the first received bit lands in bit 7.
- R5: Transmit and receive run full duplex. The byte on `rx_data` at the end of a frame is made of the 8 `miso` samples taken during that frame.
- R6: `tx_ready` returns high while a frame is shifting. A byte written during a frame starts right after that frame ends, and the `sck` edge spacing stays uniform across the frame boundary.
- R7: `dre` is 1 exactly when the holding register is empty. It drops in the cycle after a write is accepted and rises in the cycle after the byte moves into the shift register.
- R8: `txc` is set when a frame ends and no queued byte starts in its place. It is cleared in the cycle after a write is accepted.
- R9: `rx_valid` is set at the end of every frame. It stays set, with `rx_data` stable, until a cycle with `rx_ready` high. A later frame overwrites `rx_data` even if the earlier byte was never read.
- R10: While `tx_en` is 0, `tx_ready` is 0 and no new frame starts. A frame already in progress still completes, and a queued byte waits until `tx_en` returns to 1.
- R11: The engine works only when `mode_sel` is 2'b11. With any other value, `tx_ready` is 0 and `sck` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Datapath mode; 2'b11 selects the SPI master |
| tx_en | input | 1 | Allows writes and the start of new frames |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | Bit order select |
| baud | input | 12 | Half-period divider value |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` holds a byte to write |
| tx_ready | output | 1 | Holding register can take a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | All queued bytes have been shifted out |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps all four clock modes, both bit orders and three divider values. In each case it sends two queued bytes to a bit-level slave model and checks each byte in both directions. A design that shifted on the wrong edge, or reversed the bit order, would hand the slave a shifted or mirrored byte. The bench times every `sck` edge: a design that inserted an idle half-period between queued frames, or miscounted the divider, shows a stretched interval. Separate cases drop `tx_en` with a byte queued, which a wrong design would send anyway. Other cases leave the receive buffer unread across two frames, which exposes a buffer that clears itself, and use a non-SPI mode select, under which a wrong design would accept writes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [1:0] MSEL_SPI_MASTER = 2'b11;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spim_cfg_t;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int BAUD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  logic [BAUD_W-1:0] cnt;

  assign tick = run && (cnt == baud);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R2: with a nonzero divider, half-period ticks never fall on adjacent cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud != '0 && $stable(baud)) |=> !tick);
endmodule

// File: rtl/spim_txq.sv
module spim_txq #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_en,
  input  logic          wr_valid,
  input  logic [FW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  output logic          full,
  output logic [FW-1:0] data
);
  logic wr_fire;

  assign wr_ready = accept_en && !full;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_fire) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R7: an accepted write leaves the holding register occupied
  a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> full);
  // R6: a queued byte is never lost without being taken
  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> full);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [FW-1:0] load_data,
  input  spim_cfg_t     cfg,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [FW-1:0] rx_word
);
  localparam int EDGES = 2 * FW;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0] ecnt;
  logic          sck_int;
  logic [FW-1:0] tsh, rsh, rsh_in, tsh_next;
  logic          samp, shift_now;

  // sampling edges: even edge index for cpha=0, odd for cpha=1
  assign samp      = tick && (ecnt[0] == cfg.cpha);
  assign shift_now = tick && (ecnt[0] != cfg.cpha) && (ecnt != '0);
  assign done      = tick && (ecnt == LAST);

  assign rsh_in   = cfg.lsb_first ? {miso, rsh[FW-1:1]} : {rsh[FW-2:0], miso};
  assign tsh_next = cfg.lsb_first ? (tsh >> 1) : (tsh << 1);
  assign rx_word  = samp ? rsh_in : rsh;
  assign mosi     = cfg.lsb_first ? tsh[0] : tsh[FW-1];
  assign sck      = sck_int ^ cfg.cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt    <= '0;
      sck_int <= 1'b0;
      busy    <= 1'b0;
      tsh     <= '0;
      rsh     <= '0;
    end else begin
      if (tick) begin
        sck_int <= ~sck_int;
        ecnt    <= ecnt + 1'b1;
        if (samp)      rsh <= rsh_in;
        if (shift_now) tsh <= tsh_next;
        if (done)      busy <= 1'b0;
      end
      if (start) begin
        tsh  <= load_data;
        busy <= 1'b1;
        ecnt <= '0;
      end
    end
  end

  // R1: the clock rests at the polarity level between frames
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg.cpol));
  // R3: a frame ends only after its final edge
  a_r3_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done) && !$past(start)) |-> (ecnt != '0 || !$past(tick)));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int FW     = 8,
  parameter int BAUD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              tx_en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [BAUD_W-1:0] baud,
  input  logic [FW-1:0]     tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [FW-1:0]     rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              dre,
  output logic              txc,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  spim_cfg_t     cfg;
  logic          enabled, tick, busy, done, start, hold_full, wr_fire;
  logic [FW-1:0] hold_data, rx_word;

  assign cfg      = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};
  assign enabled  = tx_en && (mode_sel == MSEL_SPI_MASTER);
  assign start    = enabled && hold_full && (!busy || done);
  assign wr_fire  = tx_valid && tx_ready;
  assign dre      = !hold_full;

  spim_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .baud(baud), .tick(tick)
  );

  spim_txq #(.FW(FW)) u_txq (
    .clk(clk), .rst_n(rst_n), .accept_en(enabled), .wr_valid(tx_valid),
    .wr_data(tx_data), .wr_ready(tx_ready), .take(start),
    .full(hold_full), .data(hold_data)
  );

  spim_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .load_data(hold_data),
    .cfg(cfg), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
    .done(done), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (done && !start) txc <= 1'b1;
      if (wr_fire)        txc <= 1'b0;
      if (done) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_word;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R8: an accepted write clears transmit-complete
  a_r8_txc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !txc);
  // R9: an unread byte stays put until consumed or replaced
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));
  // R5: each frame end delivers a byte
  a_r5_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid);
  // R10: with the enable low an idle engine stays idle
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> !busy);
  // R11: outside the SPI mode no write is accepted
  a_r11_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != MSEL_SPI_MASTER) |-> !tx_ready);
endmodule

// File: tb/tb_spim_engine.sv
`timescale 1ns/1ps
module tb_spim_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic       tx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [11:0] baud = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0, rx_ready = 1'b1, miso = 1'b0;
  logic       tx_ready, rx_valid, dre, txc, sck, mosi;
  logic [7:0] rx_data;

  spim_engine dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_en(tx_en), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb_first), .baud(baud), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .dre(dre), .txc(txc), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model
  logic [7:0] s_tx [0:3];
  logic [7:0] s_rx [0:3];
  logic [7:0] rxq  [0:3];
  int   ec = 0, rxn = 0, gap_err = 0;
  bit   mon = 0;
  time  tprev = 0;
  logic mosi_q = 1'b0;

  function automatic int bpos(input int i);
    return lsb_first ? i : 7 - i;
  endfunction

  always @(negedge clk) mosi_q = mosi;

  always @(negedge clk)
    if (rx_valid && rx_ready && rxn < 4) begin
      rxq[rxn] = rx_data;
      rxn++;
    end

  always @(sck) if (mon) begin
    int f, k, bi, nb;
    if (ec > 0 && ($time - tprev) != time'((baud + 1) * 4)) gap_err++;
    tprev = $time;
    f = ec / 16; k = ec % 16; bi = k / 2;
    if ((k % 2) == int'(cpha)) begin
      if (f < 4) s_rx[f][bpos(bi)] = mosi_q;
    end else if (!cpha) begin
      nb = bi + 1;
      if (nb == 8) miso = (f + 1 < 4) ? s_tx[f+1][bpos(0)] : 1'b0;
      else if (f < 4) miso = s_tx[f][bpos(nb)];
    end else begin
      if (f < 4) miso = s_tx[f][bpos(bi)];
    end
    ec++;
  end

  task automatic arm();
    ec = 0; rxn = 0; gap_err = 0;
    for (int i = 0; i < 4; i++) begin s_rx[i] = '0; rxq[i] = '0; end
    miso = cpha ? 1'b0 : s_tx[0][bpos(0)];
    mon = 1;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic wait_txc();
    @(negedge clk);
    while (!txc) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(100000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    int bv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 1'b0, "R1 idle sck after reset", sck, 0);
    chk(dre == 1'b1, "R1 dre after reset", dre, 1);
    chk(txc == 1'b0, "R1 txc after reset", txc, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: non-SPI mode select
    mode_sel = 2'b01; tx_en = 1'b1;
    ec = 0; mon = 1; tx_valid = 1'b1; tx_data = 8'h5A;
    repeat (40) @(negedge clk);
    chk(tx_ready == 1'b0, "R11 tx_ready in other mode", tx_ready, 0);
    chk(ec == 0, "R11 sck quiet in other mode", ec, 0);
    tx_valid = 1'b0; mon = 0; mode_sel = 2'b11; tx_en = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b0, "R10 tx_ready with enable low", tx_ready, 0);
    tx_en = 1'b1;

    // sweep: mode x order x divider
    for (int cfg = 0; cfg < 24; cfg++) begin
      cpol = cfg[0]; cpha = cfg[1]; lsb_first = cfg[2];
      bv = (cfg / 8 == 0) ? 0 : (cfg / 8 == 1) ? 1 : 3;
      baud = 12'(bv);
      b0 = 8'h3C + 8'(cfg * 37);
      b1 = ~b0 ^ 8'h81;
      s_tx[0] = 8'h19 + 8'(cfg * 53);
      s_tx[1] = {s_tx[0][3:0], s_tx[0][7:4]} ^ 8'hC6;
      @(negedge clk);
      chk(sck == cpol, "R1 idle level", sck, cpol);
      arm();
      wr(b0);
      @(negedge clk);
      chk(dre == 1'b0, "R7 dre low after write", dre, 0);
      chk(txc == 1'b0, "R8 txc cleared by write", txc, 0);
      @(negedge clk);
      chk(dre == 1'b1, "R7 dre high after move", dre, 1);
      chk(tx_ready == 1'b1, "R6 ready while shifting", tx_ready, 1);
      wr(b1);
      wait_txc();
      mon = 0;
      chk(ec == 32, "R3 edge count", ec, 32);
      chk(gap_err == 0, "R2 R6 uniform edge spacing", gap_err, 0);
      chk(s_rx[0] == b0, "R3 R4 first byte at slave", s_rx[0], b0);
      chk(s_rx[1] == b1, "R3 R4 queued byte at slave", s_rx[1], b1);
      chk(rxn == 2 && rxq[0] == s_tx[0], "R5 first received byte", rxq[0], s_tx[0]);
      chk(rxq[1] == s_tx[1], "R5 second received byte", rxq[1], s_tx[1]);
      chk(txc == 1'b1 && sck == cpol, "R8 txc at burst end", txc, 1);
    end

    // R10: drop enable with a byte queued
    cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; baud = 12'd1;
    s_tx[0] = 8'hE1; s_tx[1] = 8'h2D;
    @(negedge clk);
    arm();
    wr(8'h96);
    wr(8'h4B);
    tx_en = 1'b0;
    repeat (120) @(negedge clk);
    chk(ec == 16, "R10 in-flight frame completes only", ec, 16);
    chk(txc == 1'b1, "R10 txc with byte held", txc, 1);
    chk(dre == 1'b0, "R10 byte still queued", dre, 0);
    tx_en = 1'b1;
    while (ec < 32) @(negedge clk);
    repeat (10) @(negedge clk);
    mon = 0;
    chk(s_rx[0] == 8'h96, "R10 first byte", s_rx[0], 8'h96);
    chk(s_rx[1] == 8'h4B, "R10 held byte sent after enable", s_rx[1], 8'h4B);
    chk(rxq[1] == 8'h2D, "R5 R10 byte received", rxq[1], 8'h2D);

    // R9: unread buffer holds, then gets overwritten
    rx_ready = 1'b0; cpha = 1'b1; lsb_first = 1'b1; baud = 12'd0;
    s_tx[0] = 8'h71;
    @(negedge clk);
    arm();
    wr(8'h0F);
    wait_txc();
    repeat (10) @(negedge clk);
    chk(rx_valid == 1'b1, "R9 rx_valid held", rx_valid, 1);
    chk(rx_data == 8'h71, "R9 rx_data held", rx_data, 8'h71);
    s_tx[0] = 8'hB4;
    arm();
    wr(8'hF0);
    wait_txc();
    mon = 0;
    chk(rx_valid == 1'b1 && rx_data == 8'hB4, "R9 overwrite unread", rx_data, 8'hB4);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 consumed", rx_valid, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule